// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects interrupt requests from a parameterised set of peripheral lines and from eight request bits that software sets and clears. Every source carries a programmable 4-bit priority. The controller selects the most urgent pending source and offers it to the processor with its vector number and its priority. The offer is made only when the winning priority is strictly greater than the priority of the code that is running now.

When the processor accepts an offer, the running priority is saved on a 16-entry hardware stack and is replaced by the priority of the accepted source. Nested interrupts therefore preempt only less urgent work. An end-of-interrupt strobe restores the saved level from the stack. Software can also overwrite the running priority directly, for example to raise it to a ceiling while a shared resource is held.

The offer is a valid/ready pair. `irq_vec` and `irq_pri` have meaning only while `irq_valid` is high. A transfer takes place on a rising edge where `irq_valid` and `irq_ready` are both high. Back-pressure does not freeze the offer. While it waits, the offer follows the current winner: a stronger source replaces it, and it is withdrawn if its source goes away. There is no queueing, and `irq_ready` without `irq_valid` does nothing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0, `cur_pri` is 0, `lifo_err` is 0, every source priority is 0 and the stack is empty.
- R2: A write with `cfg_we` sets the 4-bit priority of source `cfg_sel`. A source whose priority is 0 never raises a request.
- R3: `irq_valid` is high only while the offered `irq_pri` is strictly greater than `cur_pri`. A pending source whose priority is equal to or below `cur_pri` raises no request.
- R4: Source indices are assigned as follows. Index i for i < NUM_SW is software bit i. Index NUM_SW+j is `hw_req[j]`. `irq_vec` is the index of the pending source with the highest priority, and on a tie the lowest index wins. `irq_pri` is that source's priority.
- R5: Latency is exactly three clocks. Suppose a request on `hw_req` or a `sw_set` pulse is present before rising edge k, and the source wins and exceeds `cur_pri`. Then `irq_valid` is low after edge k+1 and high after edge k+2.
- R6: A transfer (`irq_valid` and `irq_ready` high at an edge) does two things: it pushes `cur_pri` onto the stack and sets `cur_pri` to `irq_pri`. `irq_ready` while `irq_valid` is low has no effect.
- R7: An `eoi` strobe pops the stack into `cur_pri`.
- R8: A `cpr_we` strobe loads `cpr_wdata` into `cur_pri`. Lowering the value releases a waiting source on the next edge, and raising it holds such a source back.
- R9: A software source pends on `sw_set` and clears on `sw_clr`. When both arrive in the same cycle, the clear wins. The source also clears when its request is transferred.
- R10: A peripheral source pends for as long as its `hw_req` line is high. A transfer does not clear it.
- R11: The stack holds 16 entries. A push when the stack is full drops the value, although `cur_pri` still takes the source priority. A pop when the stack is empty leaves `cur_pri` unchanged. Both cases set `lifo_err`, which stays high until reset.
- R12: When strobes arrive together, a transfer takes precedence over `eoi`, and `eoi` takes precedence over `cpr_we`. The lower-ranked strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| hw_req | input | NUM_HW | Peripheral request levels |
| sw_set | input | NUM_SW | Set software request bits |
| sw_clr | input | NUM_SW | Clear software request bits |
| cfg_we | input | 1 | Priority write strobe |
| cfg_sel | input | $clog2(NUM_HW+NUM_SW) | Source index of the priority write |
| cfg_pri | input | 4 | Priority value written |
| cpr_we | input | 1 | Running priority write strobe |
| cpr_wdata | input | 4 | Running priority value |
| irq_valid | output | 1 | Request offered to the processor |
| irq_ready | input | 1 | Processor accepts the offer |
| irq_vec | output | 9 | Vector of the offered source |
| irq_pri | output | 4 | Priority of the offered source |
| eoi | input | 1 | End-of-interrupt strobe |
| cur_pri | output | 4 | Running priority |
| lifo_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions assume that `irq_ready`, `eoi`, `cpr_we` and `cfg_we` come from one processor, are synchronous to `clk`, and are single-cycle strobes. They also assume that an end-of-interrupt follows its matching transfer, apart from the deliberate underflow case. The bench raises each strobe for exactly one cycle from a task. It drives `irq_ready` only after it has seen `irq_valid`, except in one deliberate test. It combines strobes only in the precedence tests and drives stack overflow and underflow on purpose.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int PRI_W = 4;
  localparam int VEC_W = 9;
  typedef logic [PRI_W-1:0] pri_t;
endpackage

// File: rtl/pic_pending.sv
`timescale 1ns/1ps
// Captures request levels and keeps the software request bits.
module pic_pending #(
  parameter int NUM_HW = 16,
  parameter int NUM_SW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_HW-1:0]        hw_req,
  input  logic [NUM_SW-1:0]        sw_set,
  input  logic [NUM_SW-1:0]        sw_clr,
  input  logic [NUM_SW-1:0]        sw_ack,
  output logic [NUM_HW+NUM_SW-1:0] pend
);
  logic [NUM_HW-1:0] hw_q;
  logic [NUM_SW-1:0] sw_q;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_hw
    always_ff @(posedge clk) begin
      if (!rst_n) hw_q[g] <= 1'b0;
      else        hw_q[g] <= hw_req[g];
    end
  end

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    always_ff @(posedge clk) begin
      if (!rst_n)                     sw_q[g] <= 1'b0;
      else if (sw_clr[g] || sw_ack[g]) sw_q[g] <= 1'b0;
      else if (sw_set[g])              sw_q[g] <= 1'b1;
    end
  end

  assign pend = {hw_q, sw_q};
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
// Priority registers and registered winner selection.
module pic_arbiter import pic_pkg::*; #(
  parameter int NSRC  = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  mask,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  pri_t             cfg_pri,
  output logic             win_valid,
  output pri_t             win_pri,
  output logic [IDX_W-1:0] win_idx
);
  pri_t             prio_q [NSRC];
  pri_t             best_pri;
  logic [IDX_W-1:0] best_idx;
  logic [NSRC-1:0]  live;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (!rst_n)                                  prio_q[i] <= '0;
      else if (cfg_we && cfg_sel == IDX_W'(i))     prio_q[i] <= cfg_pri;
    end
  end

  assign live = pend & ~mask;

  // Strict compare: earlier index keeps a tie; zero priority never wins.
  always_comb begin
    best_pri = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (live[i] && prio_q[i] > best_pri) begin
        best_pri = prio_q[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_pri   <= '0;
      win_idx   <= '0;
    end else begin
      win_valid <= (best_pri != '0);
      win_pri   <= best_pri;
      win_idx   <= best_idx;
    end
  end
endmodule

// File: rtl/pic_lifo.sv
`timescale 1ns/1ps
// Saved-priority stack with sticky misuse flag.
module pic_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic             err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [LVL_W-1:0] lvl_q;
  logic             full;

  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign empty = (lvl_q == '0);
  assign level = lvl_q;
  assign dout  = mem[AW'(lvl_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (push && !full) mem[AW'(lvl_q)] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      err   <= 1'b0;
    end else if (push) begin
      if (full) err   <= 1'b1;
      else      lvl_q <= lvl_q + 1'b1;
    end else if (pop) begin
      if (empty) err   <= 1'b1;
      else       lvl_q <= lvl_q - 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Preemptive priority interrupt controller, top level.
module prio_irq_ctrl import pic_pkg::*; #(
  parameter int NUM_HW     = 16,
  parameter int NUM_SW     = 8,
  parameter int LIFO_DEPTH = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_HW-1:0]                   hw_req,
  input  logic [NUM_SW-1:0]                   sw_set,
  input  logic [NUM_SW-1:0]                   sw_clr,
  input  logic                                cfg_we,
  input  logic [$clog2(NUM_HW+NUM_SW)-1:0]    cfg_sel,
  input  logic [PRI_W-1:0]                    cfg_pri,
  input  logic                                cpr_we,
  input  logic [PRI_W-1:0]                    cpr_wdata,
  output logic                                irq_valid,
  input  logic                                irq_ready,
  output logic [VEC_W-1:0]                    irq_vec,
  output logic [PRI_W-1:0]                    irq_pri,
  input  logic                                eoi,
  output logic [PRI_W-1:0]                    cur_pri,
  output logic                                lifo_err
);
  localparam int NSRC  = NUM_HW + NUM_SW;
  localparam int IDX_W = $clog2(NSRC);
  localparam int LVL_W = $clog2(LIFO_DEPTH + 1);

  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   clr_mask;
  logic [NUM_SW-1:0] sw_ack;
  logic              win_valid;
  pri_t              win_pri;
  logic [IDX_W-1:0]  win_idx;
  logic              hs, push, pop;
  pri_t              cpr_n, lifo_top;
  logic              lifo_empty;
  logic [LVL_W-1:0]  lifo_lvl;

  assign hs = irq_valid && irq_ready;

  always_comb begin
    for (int i = 0; i < NUM_SW; i++) sw_ack[i] = hs && (irq_vec == VEC_W'(i));
  end
  assign clr_mask = {{NUM_HW{1'b0}}, sw_ack};

  pic_pending #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set),
    .sw_clr(sw_clr), .sw_ack(sw_ack), .pend(pend)
  );

  pic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(clr_mask),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pri(cfg_pri),
    .win_valid(win_valid), .win_pri(win_pri), .win_idx(win_idx)
  );

  pic_lifo #(.DEPTH(LIFO_DEPTH), .W(PRI_W), .LVL_W(LVL_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(cur_pri),
    .dout(lifo_top), .empty(lifo_empty), .level(lifo_lvl), .err(lifo_err)
  );

  // Running priority: transfer, then end-of-interrupt, then direct write.
  always_comb begin
    cpr_n = cur_pri;
    push  = 1'b0;
    pop   = 1'b0;
    if (hs) begin
      push  = 1'b1;
      cpr_n = irq_pri;
    end else if (eoi) begin
      pop = 1'b1;
      if (!lifo_empty) cpr_n = lifo_top;
    end else if (cpr_we) begin
      cpr_n = cpr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_pri <= '0;
    else        cur_pri <= cpr_n;
  end

  // Offer stage compares against the running priority it will coexist with.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_pri   <= '0;
    end else begin
      irq_valid <= win_valid && (win_pri > cpr_n);
      irq_vec   <= VEC_W'(win_idx);
      irq_pri   <= win_pri;
    end
  end
endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker #(
  parameter int LIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [3:0]       irq_pri,
  input logic             eoi,
  input logic             cpr_we,
  input logic [3:0]       cpr_wdata,
  input logic [3:0]       cur_pri,
  input logic             lifo_err,
  input logic [LVL_W-1:0] lifo_lvl
);
  a_r3_above_running: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_pri > cur_pri);

  a_r2_no_zero_offer: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_pri != 4'd0);

  a_r6_take_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> cur_pri == $past(irq_pri));

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && int'(lifo_lvl) < LIFO_DEPTH)
      |=> int'(lifo_lvl) == int'($past(lifo_lvl)) + 1);

  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(irq_valid && irq_ready) && lifo_lvl != '0)
      |=> int'(lifo_lvl) == int'($past(lifo_lvl)) - 1);

  a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpr_we && !eoi && !(irq_valid && irq_ready)) |=> cur_pri == $past(cpr_wdata));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lifo_err |=> lifo_err);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lifo_lvl) <= LIFO_DEPTH);

  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_valid && irq_ready) && !eoi && !cpr_we) |=> $stable(cur_pri));
endmodule

bind prio_irq_ctrl pic_checker #(
  .LIFO_DEPTH(LIFO_DEPTH), .LVL_W($clog2(LIFO_DEPTH + 1))
) u_pic_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_pri(irq_pri), .eoi(eoi), .cpr_we(cpr_we), .cpr_wdata(cpr_wdata),
  .cur_pri(cur_pri), .lifo_err(lifo_err), .lifo_lvl(lifo_lvl)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int NUM_HW = 16;
  localparam int NUM_SW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_HW-1:0] hw_req = '0;
  logic [NUM_SW-1:0] sw_set = '0, sw_clr = '0;
  logic              cfg_we = 1'b0;
  logic [4:0]        cfg_sel = '0;
  logic [3:0]        cfg_pri = '0;
  logic              cpr_we = 1'b0;
  logic [3:0]        cpr_wdata = '0;
  logic              irq_valid, irq_ready = 1'b0;
  logic [8:0]        irq_vec;
  logic [3:0]        irq_pri;
  logic              eoi = 1'b0;
  logic [3:0]        cur_pri;
  logic              lifo_err;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int exp_vec_q[$];
  int exp_pri_q[$];
  int stack_m[$];

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .LIFO_DEPTH(16)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pri(cfg_pri), .cpr_we(cpr_we),
    .cpr_wdata(cpr_wdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vec(irq_vec), .irq_pri(irq_pri), .eoi(eoi), .cur_pri(cur_pri),
    .lifo_err(lifo_err)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every transfer is compared against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      n_vec++;
      if (exp_vec_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4: unexpected transfer vec %0d expected none", irq_vec);
      end else begin
        int ev, ep;
        ev = exp_vec_q.pop_front();
        ep = exp_pri_q.pop_front();
        if (int'(irq_vec) != ev || int'(irq_pri) != ep) begin
          n_bad++;
          $display("FAIL R4: transfer vec/pri %0d/%0d expected %0d/%0d",
                   irq_vec, irq_pri, ev, ep);
        end
      end
    end
  end

  task automatic cfg(input int sel, input int p);
    cfg_sel = 5'(sel); cfg_pri = 4'(p); cfg_we = 1'b1; tick(); cfg_we = 1'b0;
  endtask

  task automatic cpr(input int v);
    cpr_wdata = 4'(v); cpr_we = 1'b1; tick(); cpr_we = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; tick(); eoi = 1'b0;
  endtask

  task automatic swset(input int i);
    sw_set[i] = 1'b1; tick(); sw_set = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // Driver: wait for an offer, queue the expectation, accept it.
  task automatic take(input int vec, input int p, input bit with_eoi);
    for (int k = 0; k < 10 && !irq_valid; k++) tick();
    if (!irq_valid) chk("R4 offer present", 0, 1);
    exp_vec_q.push_back(vec);
    exp_pri_q.push_back(p);
    irq_ready = 1'b1; eoi = with_eoi;
    tick();
    irq_ready = 1'b0; eoi = 1'b0;
    chk("R6 running priority after transfer", int'(cur_pri), p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    tick();
    chk("R1 irq_valid at reset", int'(irq_valid), 0);
    chk("R1 cur_pri at reset", int'(cur_pri), 0);
    chk("R1 lifo_err at reset", int'(lifo_err), 0);

    // R2: unconfigured priority (0) never requests
    swset(2); idle(4);
    chk("R2 zero priority silent", int'(irq_valid), 0);
    sw_clr[2] = 1'b1; tick(); sw_clr = '0;

    cfg(8, 5); cfg(9, 5); cfg(10, 9); cfg(3, 7);

    // R5 latency and R4 tie by lowest index
    hw_req[0] = 1'b1; hw_req[1] = 1'b1;
    idle(2);
    chk("R5 no request after two edges", int'(irq_valid), 0);
    tick();
    chk("R5 request after three edges", int'(irq_valid), 1);
    chk("R4 tie goes to lowest index", int'(irq_vec), 8);
    take(8, 5, 0);
    idle(4);
    chk("R3 equal priority held back", int'(irq_valid), 0);

    // preemption by a stronger peripheral
    hw_req[2] = 1'b1;
    take(10, 9, 0);
    do_eoi();
    chk("R7 pop restores 5", int'(cur_pri), 5);
    idle(3);
    chk("R10 peripheral still pending after transfer", int'(irq_valid), 1);
    chk("R10 vector of held peripheral", int'(irq_vec), 10);
    hw_req = '0;
    idle(3);
    chk("R10 deassert withdraws request", int'(irq_valid), 0);
    do_eoi();
    chk("R7 pop restores 0", int'(cur_pri), 0);

    // software sources
    swset(3); tick();
    chk("R5 software source not yet offered", int'(irq_valid), 0);
    tick();
    chk("R5 software source offered on third edge", int'(irq_valid), 1);
    take(3, 7, 0);
    do_eoi(); idle(4);
    chk("R9 transfer cleared software bit", int'(irq_valid), 0);
    sw_set[3] = 1'b1; sw_clr[3] = 1'b1; tick(); sw_set = '0; sw_clr = '0;
    idle(4);
    chk("R9 clear wins over set", int'(irq_valid), 0);

    // priority ceiling
    cpr(8);
    chk("R8 direct write", int'(cur_pri), 8);
    swset(3); idle(4);
    chk("R8 raised level holds back source", int'(irq_valid), 0);
    cpr(6);
    chk("R8 lowered level releases source", int'(irq_valid), 1);
    take(3, 7, 0);
    do_eoi();
    chk("R7 pop restores written level", int'(cur_pri), 6);
    cpr(0);

    // same priority, software beats peripheral by index
    cfg(5, 12); cfg(20, 12);
    hw_req[12] = 1'b1; swset(5);
    take(5, 12, 0);
    idle(4);
    chk("R3 peripheral at equal level held back", int'(irq_valid), 0);
    hw_req = '0; idle(3);
    do_eoi();
    chk("R7 back to 0", int'(cur_pri), 0);

    // precedence of strobes
    swset(3);
    take(3, 7, 1);
    chk("R12 eoi dropped under transfer", int'(lifo_err), 0);
    do_eoi();
    chk("R12 stack held one entry", int'(cur_pri), 0);
    chk("R12 no underflow", int'(lifo_err), 0);
    swset(3);
    take(3, 7, 0);
    cpr_wdata = 4'd9; cpr_we = 1'b1; eoi = 1'b1; tick(); cpr_we = 1'b0; eoi = 1'b0;
    chk("R12 eoi wins over write", int'(cur_pri), 0);
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
    chk("R6 ready without valid ignored", int'(cur_pri), 0);

    // R11 overflow
    cfg(0, 15);
    for (int i = 0; i < 17; i++) begin
      int w;
      w = (i < 16) ? (i % 15) : 3;
      cpr(w);
      if (stack_m.size() < 16) stack_m.push_back(w);
      swset(0);
      take(0, 15, 0);
      if (i == 15) chk("R11 full stack no error", int'(lifo_err), 0);
    end
    chk("R11 overflow sets error", int'(lifo_err), 1);
    for (int i = 0; i < 16; i++) begin
      int e;
      e = stack_m.pop_back();
      do_eoi();
      chk("R11 stack contents preserved", int'(cur_pri), e);
    end
    cpr(4);
    do_eoi();
    chk("R11 underflow leaves level", int'(cur_pri), 4);
    chk("R11 error sticky", int'(lifo_err), 1);

    // reset again, then underflow alone
    rst_n = 1'b0; idle(2); rst_n = 1'b1; tick();
    chk("R1 error cleared by reset", int'(lifo_err), 0);
    chk("R1 cur_pri cleared by reset", int'(cur_pri), 0);
    do_eoi();
    chk("R11 underflow sets error", int'(lifo_err), 1);
    chk("R11 underflow keeps 0", int'(cur_pri), 0);
    chk("R4 scoreboard drained", exp_vec_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule